// File: doc/BRIEF.md
# Microcoded Indirect Jump-and-Link Engine

This block is a small single-bus datapath run by a microcode sequencer. It executes a jump-and-link whose target is read from memory: the instruction names a base register and a signed 16-bit offset. Their sum addresses a memory word, and that word becomes the new program counter. The return address goes to the highest-numbered register. Every storage element shares one bus: the register file, two operand latches, a memory-address latch, the program counter and the instruction register. Each micro-step places one source on the bus and loads any set of destinations.

An instruction takes eight micro-steps. The first three are a plain fetch. Step 0 copies PC into operand latch A and the address latch. Step 1 loads the instruction word. Step 2 writes A+4 back to PC. The jump then takes five steps and leans on two facts. Latch A still holds the pre-increment PC, so the link value is A+4, computed without reading PC again. Addition commutes, so the base register can sit in latch B while the sign-extended offset is loaded into A afterwards. The memory is a word-addressed read-only store whose contents follow a fixed formula, and the register file also starts from a formula. A run therefore needs nothing but a clock and a reset release.

Top module: `jalm_engine`

## Requirements
- R1: While reset is asserted, `pc_o` is zero, `upc_o` is zero and both strobes `link_valid_o` and `jump_valid_o` are low.
- R2: After reset, `upc_o` steps 0,1,...,7 and then returns to 0, one step per clock. `link_valid_o` is high only in step 4, `jump_valid_o` only in step 7, and the two are never high together.
- R3: PC changes only at the ends of steps 2 and 7. The end of step 2 adds 4 to it.
- R4: In step 4 the value written to register 31 (`link_data_o`) equals the pre-fetch PC plus 4. This equals the PC already incremented, not the pre-fetch PC plus 8.
- R5: The offset is bits [15:0] of the instruction word, sign-extended to 32 bits. Negative offsets subtract from the base.
- R6: The memory word index is bits [9:2] of (sign-extended offset + R[rs]), where rs is instruction bits [25:21]. R[0] reads as zero. The base is read in step 3, before step 4 overwrites register 31.
- R7: In step 7 `jump_target_o` carries the memory word at that index, and `pc_o` shows it from the next step 0. The next fetch uses PC bits [9:2] as its word index.
- R8: Initial contents. At reset register i holds 16*i. Memory word w (8-bit index) holds {6'h0d, w[4:0], 5'b0, imm}, where imm = {{8{w[0]}}, w[7:0]} XOR 16'h0024.
- R9: Counting clock edges from reset release, the k-th instruction (k from 0) raises `jump_valid_o` in cycle 8k+7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| pc_o | output | 32 | Program counter |
| upc_o | output | 3 | Current micro-step index |
| link_valid_o | output | 1 | Register-31 write strobe (step 4) |
| link_data_o | output | 32 | Return address being written |
| jump_valid_o | output | 1 | PC load from memory strobe (step 7) |
| jump_target_o | output | 32 | Memory word loaded into PC |

## Verification
The assertions take for granted that reset is released once, between clock edges, and that nothing else drives the block. Under that condition the micro-step index alone decides which latch loads. Every relation in the checker is then fixed by the step order: the link value matches the already incremented PC, and PC holds still outside steps 2 and 7. The stimulus is only that single reset release. The formula contents start the chain at word 0, whose base register is r0. The second instruction carries a negative offset, so both the zero register and sign extension are reached in the first two jumps.

// File: rtl/jalm_pkg.sv
package jalm_pkg;
  localparam int unsigned UPC_W  = 3;
  localparam int unsigned RS_LSB = 21;
  localparam int unsigned RS_W   = 5;
  localparam int unsigned IMM_W  = 16;

  localparam logic [UPC_W-1:0] ST_FETCH_A  = 3'd0;
  localparam logic [UPC_W-1:0] ST_FETCH_IR = 3'd1;
  localparam logic [UPC_W-1:0] ST_PC_INC   = 3'd2;
  localparam logic [UPC_W-1:0] ST_BASE     = 3'd3;
  localparam logic [UPC_W-1:0] ST_LINK     = 3'd4;
  localparam logic [UPC_W-1:0] ST_OFFS     = 3'd5;
  localparam logic [UPC_W-1:0] ST_ADDR     = 3'd6;
  localparam logic [UPC_W-1:0] ST_JUMP     = 3'd7;

  typedef enum logic [2:0] {
    SRC_PC  = 3'd0,
    SRC_ALU = 3'd1,
    SRC_REG = 3'd2,
    SRC_IMM = 3'd3,
    SRC_MEM = 3'd4
  } bus_src_e;

  typedef enum logic {
    ALU_PLUS4 = 1'b0,
    ALU_ADDB  = 1'b1
  } alu_op_e;

  typedef struct packed {
    bus_src_e src;
    alu_op_e  alu;
    logic     ld_a;
    logic     ld_b;
    logic     ld_ma;
    logic     ld_pc;
    logic     ld_ir;
    logic     rf_we;
    logic     last;
  } uop_t;
endpackage

// File: rtl/jalm_useq.sv
module jalm_useq
  import jalm_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  output logic [UPC_W-1:0] upc_o,
  output uop_t             uop_o
);
  logic [UPC_W-1:0] upc_q;

  function automatic uop_t rom(input logic [UPC_W-1:0] s);
    uop_t u;
    u = '0;
    u.src = SRC_PC;
    u.alu = ALU_PLUS4;
    case (s)
      ST_FETCH_A:  begin u.src = SRC_PC;  u.ld_a = 1'b1; u.ld_ma = 1'b1; end
      ST_FETCH_IR: begin u.src = SRC_MEM; u.ld_ir = 1'b1; end
      ST_PC_INC:   begin u.src = SRC_ALU; u.alu = ALU_PLUS4; u.ld_pc = 1'b1; end
      ST_BASE:     begin u.src = SRC_REG; u.ld_b = 1'b1; end
      // A still holds the pre-fetch PC
      ST_LINK:     begin u.src = SRC_ALU; u.alu = ALU_PLUS4; u.rf_we = 1'b1; end
      ST_OFFS:     begin u.src = SRC_IMM; u.ld_a = 1'b1; end
      ST_ADDR:     begin u.src = SRC_ALU; u.alu = ALU_ADDB; u.ld_ma = 1'b1; end
      ST_JUMP:     begin u.src = SRC_MEM; u.ld_pc = 1'b1; u.last = 1'b1; end
      default:     u = '0;
    endcase
    return u;
  endfunction

  assign uop_o = rom(upc_q);
  assign upc_o = upc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         upc_q <= '0;
    else if (uop_o.last) upc_q <= '0;
    else                 upc_q <= upc_q + 1'b1;
  end
endmodule

// File: rtl/jalm_regfile.sv
module jalm_regfile #(
  parameter int unsigned XLEN   = 32,
  parameter int unsigned NREG   = 32,
  parameter int unsigned STRIDE = 16,
  localparam int unsigned RA_W  = $clog2(NREG)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [RA_W-1:0] raddr_i,
  output logic [XLEN-1:0] rdata_o,
  input  logic            we_i,
  input  logic [RA_W-1:0] waddr_i,
  input  logic [XLEN-1:0] wdata_i
);
  logic [NREG-1:0][XLEN-1:0] regs_flat;

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    if (g == 0) begin : g_zero
      assign regs_flat[g] = '0;
    end else begin : g_live
      logic [XLEN-1:0] q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                           q <= XLEN'(g * STRIDE);
        else if (we_i && waddr_i == RA_W'(g))  q <= wdata_i;
      end
      assign regs_flat[g] = q;
    end
  end

  assign rdata_o = regs_flat[raddr_i];
endmodule

// File: rtl/jalm_mem.sv
module jalm_mem #(
  parameter int unsigned XLEN = 32,
  parameter int unsigned AW   = 8
) (
  input  logic [AW-1:0]   addr_i,
  output logic [XLEN-1:0] rdata_o
);
  // Contents are a closed-form function of the word index
  function automatic logic [XLEN-1:0] word_at(input logic [AW-1:0] a);
    logic [15:0] ext;
    logic [15:0] imm;
    ext = 16'(a);
    imm = {{8{ext[0]}}, ext[7:0]} ^ 16'h0024;
    return XLEN'({6'h0d, ext[4:0], 5'b0, imm});
  endfunction

  assign rdata_o = word_at(addr_i);
endmodule

// File: rtl/jalm_engine.sv
module jalm_engine
  import jalm_pkg::*;
#(
  parameter int unsigned      XLEN       = 32,
  parameter int unsigned      NREG       = 32,
  parameter int unsigned      MEM_AW     = 8,
  parameter int unsigned      REG_STRIDE = 16,
  parameter logic [XLEN-1:0]  RESET_PC   = '0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  output logic [XLEN-1:0]  pc_o,
  output logic [UPC_W-1:0] upc_o,
  output logic             link_valid_o,
  output logic [XLEN-1:0]  link_data_o,
  output logic             jump_valid_o,
  output logic [XLEN-1:0]  jump_target_o
);
  localparam int unsigned RA_W     = $clog2(NREG);
  localparam int unsigned LINK_REG = NREG - 1;
  localparam int unsigned WORD_LSB = 2;

  uop_t             uop;
  logic [XLEN-1:0]  bus;
  logic [XLEN-1:0]  alu;
  logic [XLEN-1:0]  a_q, b_q, pc_q;
  logic [MEM_AW-1:0] ma_q;
  logic [RA_W-1:0]  rs_q;
  logic [IMM_W-1:0] imm_q;
  logic [XLEN-1:0]  imm_sext;
  logic [XLEN-1:0]  rf_rdata;
  logic [XLEN-1:0]  mem_rdata;

  jalm_useq u_useq (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .upc_o  (upc_o),
    .uop_o  (uop)
  );

  jalm_regfile #(
    .XLEN   (XLEN),
    .NREG   (NREG),
    .STRIDE (REG_STRIDE)
  ) u_rf (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .raddr_i (rs_q),
    .rdata_o (rf_rdata),
    .we_i    (uop.rf_we),
    .waddr_i (RA_W'(LINK_REG)),
    .wdata_i (bus)
  );

  jalm_mem #(
    .XLEN (XLEN),
    .AW   (MEM_AW)
  ) u_mem (
    .addr_i  (ma_q),
    .rdata_o (mem_rdata)
  );

  assign imm_sext = {{(XLEN-IMM_W){imm_q[IMM_W-1]}}, imm_q};
  assign alu      = a_q + ((uop.alu == ALU_ADDB) ? b_q : XLEN'(4));

  always_comb begin
    case (uop.src)
      SRC_PC:  bus = pc_q;
      SRC_ALU: bus = alu;
      SRC_REG: bus = rf_rdata;
      SRC_IMM: bus = imm_sext;
      SRC_MEM: bus = mem_rdata;
      default: bus = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      a_q   <= '0;
      b_q   <= '0;
      pc_q  <= RESET_PC;
      ma_q  <= '0;
      rs_q  <= '0;
      imm_q <= '0;
    end else begin
      if (uop.ld_a)  a_q  <= bus;
      if (uop.ld_b)  b_q  <= bus;
      if (uop.ld_pc) pc_q <= bus;
      if (uop.ld_ma) ma_q <= bus[WORD_LSB +: MEM_AW];
      if (uop.ld_ir) begin
        rs_q  <= bus[RS_LSB +: RS_W];
        imm_q <= bus[IMM_W-1:0];
      end
    end
  end

  assign pc_o          = pc_q;
  assign link_valid_o  = uop.rf_we;
  assign link_data_o   = bus;
  assign jump_valid_o  = uop.ld_pc & (uop.src == SRC_MEM);
  assign jump_target_o = bus;
endmodule

// File: rtl/jalm_engine_chk.sv
module jalm_engine_chk
  import jalm_pkg::*;
#(
  parameter int unsigned XLEN = 32
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [XLEN-1:0]  pc_o,
  input logic [UPC_W-1:0] upc_o,
  input logic             link_valid_o,
  input logic [XLEN-1:0]  link_data_o,
  input logic             jump_valid_o,
  input logic [XLEN-1:0]  jump_target_o
);
  // R2
  upc_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upc_o == ST_JUMP |=> upc_o == ST_FETCH_A);
  // R2
  upc_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upc_o != ST_JUMP |=> upc_o == $past(upc_o) + 1'b1);
  // R2
  link_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    link_valid_o |-> upc_o == ST_LINK);
  // R9
  jump_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    jump_valid_o |-> upc_o == ST_JUMP);
  // R2
  strobe_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(link_valid_o && jump_valid_o));
  // R4
  link_value_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    link_valid_o |-> link_data_o == pc_o);
  // R3
  pc_inc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upc_o == ST_PC_INC |=> pc_o == $past(pc_o) + XLEN'(4));
  // R3
  pc_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upc_o != ST_PC_INC && upc_o != ST_JUMP) |=> $stable(pc_o));
  // R7
  pc_target_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    jump_valid_o |=> pc_o == $past(jump_target_o));
endmodule

bind jalm_engine jalm_engine_chk #(.XLEN(XLEN)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .pc_o          (pc_o),
  .upc_o         (upc_o),
  .link_valid_o  (link_valid_o),
  .link_data_o   (link_data_o),
  .jump_valid_o  (jump_valid_o),
  .jump_target_o (jump_target_o)
);

// File: tb/jalm_engine_tb.sv
module jalm_engine_tb;
  localparam int NINST = 24;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [31:0] pc_o, link_data_o, jump_target_o;
  logic [2:0]  upc_o;
  logic        link_valid_o, jump_valid_o;

  always #5 clk = ~clk;

  jalm_engine u_dut (
    .clk_i         (clk),
    .rst_ni        (rst_ni),
    .pc_o          (pc_o),
    .upc_o         (upc_o),
    .link_valid_o  (link_valid_o),
    .link_data_o   (link_data_o),
    .jump_valid_o  (jump_valid_o),
    .jump_target_o (jump_target_o)
  );

  typedef struct {
    logic [31:0] pc;
    logic [31:0] link;
    logic [31:0] target;
    bit          neg;
    bit          rs_zero;
  } exp_t;

  exp_t sb_q[$];
  int   n_run = 0;
  int   n_fail = 0;
  int   neg_seen = 0;
  bit   done = 1'b0;

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  // R8 memory formula
  function automatic logic [31:0] ref_mem(input logic [7:0] w);
    logic [15:0] imm;
    imm = {{8{w[0]}}, w} ^ 16'h0024;
    return {6'h0d, w[4:0], 5'd0, imm};
  endfunction

  // Driver: reference model pushes expected items
  task automatic drive_model();
    logic [31:0] rf [32];
    logic [31:0] pc, ir, b, ma;
    logic [4:0]  rs;
    exp_t        e;
    for (int i = 0; i < 32; i++) rf[i] = 32'(i * 16);
    pc = 32'h0;
    for (int k = 0; k < NINST; k++) begin
      ir        = ref_mem(pc[9:2]);
      rs        = ir[25:21];
      b         = (rs == 5'd0) ? 32'h0 : rf[rs];
      e.pc      = pc;
      e.link    = pc + 32'd4;
      rf[31]    = e.link;
      ma        = {{16{ir[15]}}, ir[15:0]} + b;
      e.target  = ref_mem(ma[9:2]);
      e.neg     = ir[15];
      e.rs_zero = (rs == 5'd0);
      if (e.neg) neg_seen++;
      sb_q.push_back(e);
      pc = e.target;
    end
  endtask

  initial begin
    logic [31:0] exp_pc;
    drive_model();
    repeat (3) @(negedge clk);
    // R1
    check(pc_o == 32'h0, "R1 reset pc", pc_o, 32'h0);
    check(upc_o == 3'd0, "R1 reset upc", 32'(upc_o), 32'h0);
    check(!link_valid_o && !jump_valid_o, "R1 reset strobes",
          32'({link_valid_o, jump_valid_o}), 32'h0);
    rst_ni = 1'b1;
    exp_pc = 32'h0;
    for (int n = 0; n < NINST * 8; n++) begin
      int st;
      if (n > 0) @(negedge clk);
      st = n % 8;
      // R2
      check(32'(upc_o) == 32'(st), "R2 step index", 32'(upc_o), 32'(st));
      if (st == 0)
        check(pc_o == exp_pc, "R7 pc after jump", pc_o, exp_pc);
      if (st == 3)
        check(pc_o == exp_pc + 32'd4, "R3 pc incremented", pc_o, exp_pc + 32'd4);
      check(link_valid_o == (st == 4), "R2 link strobe step",
            32'(link_valid_o), 32'(st == 4));
      // R9
      check(jump_valid_o == (st == 7), "R9 jump cycle",
            32'(jump_valid_o), 32'(st == 7));
      if (link_valid_o && sb_q.size() > 0)
        check(link_data_o == sb_q[0].link, "R4 link value", link_data_o, sb_q[0].link);
      if (jump_valid_o && sb_q.size() > 0) begin
        exp_t e;
        e = sb_q.pop_front();
        if (e.rs_zero)
          check(jump_target_o == e.target, "R6 r0 base target", jump_target_o, e.target);
        else if (e.neg)
          check(jump_target_o == e.target, "R5 negative offset target", jump_target_o, e.target);
        else
          check(jump_target_o == e.target, "R6 target", jump_target_o, e.target);
        exp_pc = e.target;
      end
    end
    // R5 stimulus must have reached a negative offset
    check(neg_seen > 0, "R5 negative offset exercised", 32'(neg_seen), 32'h1);
    check(sb_q.size() == 0, "R9 all jumps observed", 32'(sb_q.size()), 32'h0);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #(200000 * 10);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog act=%h exp=%h", 32'h0, 32'h1);
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule